// File: doc/BRIEF.md
# Two-Tone Keyed Packet Transmitter

This block turns queued 9-bit key codes into an audio sample stream. Each code is wrapped in a 12-slot frame: a low start slot, the nine code bits least significant first, an odd-parity slot and a high stop slot. The frame goes out as two independently gated tones. A high-pitched "clock" tone is on for the first half of every slot and off for the second half, so a receiver's tone detector sees a falling clock edge in mid-slot. A lower "data" tone is on for the whole slot whenever that slot's bit is 1. After the last slot a fixed stretch of silence follows before the next frame may start.

Both tones come from phase accumulators that step once per sample-rate tick. Each accumulator's top bit is used as a square wave. The gated tones are summed around midscale into an unsigned sample that feeds a PWM or DAC stage. Codes arrive on a valid/ready port into a small FIFO, so a writer can queue several codes while a frame is still being sent. Slot length, gap length, the two phase increments and the FIFO depth are parameters.

Top module: `twoToneKeyer`

## Requirements
- R1: After reset, `audioSample` equals midscale (2^(SAMPLE_W-1)), `codeReady` is 1, both phase accumulators are zero and no frame is in progress.
- R2: `codeReady` is 1 exactly when fewer than FIFO_DEPTH codes are queued. A code is accepted on a clock edge where `codeValid` and `codeReady` are both 1. Accepted codes are sent in order of arrival, and none is lost or duplicated.
- R3: A frame is 12 slots numbered 0 to 11. Slot 0 carries 0. Slot k for k = 1 to 9 carries code bit k-1. Slot 10 carries the parity bit, chosen so that the nine code bits plus parity hold an odd number of ones. Slot 11 carries 1.
- R4: The data tone is enabled throughout a slot whose bit is 1 and is disabled throughout a slot whose bit is 0.
- R5: The clock tone is enabled during the first SLOT_TICKS/2 ticks of each slot (in-slot tick count 0 to SLOT_TICKS/2-1) and disabled for the rest of the slot.
- R6: Each slot lasts exactly SLOT_TICKS sample ticks. After slot 11 both tones stay off for exactly GAP_TICKS ticks, and only then may another frame start.
- R7: Each phase accumulator is PHASE_W bits wide and advances by its increment (CLK_INC, DAT_INC) modulo 2^PHASE_W on every tick, whether or not its tone is enabled. `audioSample` changes only on the clock edge that follows a cycle with `sampleTick` high.
- R8: On a tick, the new sample is midscale plus a term for each enabled tone. The term is +AMP when the top bit of that tone's updated accumulator is 1 and -AMP when it is 0, with AMP = 2^(SAMPLE_W-2)-1. The tone gates are those in force in the tick cycle.
- R9: On a tick where neither tone is enabled (idle, gap, or second half of a slot whose bit is 0), the sample is exactly midscale.
- R10: When idle with at least one queued code, the transmitter takes the oldest code and starts slot 0 on the next clock edge, without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| codeValid | input | 1 | A code is offered on `codeIn` |
| codeIn | input | CODE_W (9) | Key code to send |
| codeReady | output | 1 | FIFO has room for a code |
| sampleTick | input | 1 | One-cycle strobe at the audio sample rate |
| audioSample | output | SAMPLE_W (8) | Unsigned audio sample, midscale when silent |

## Verification
The hardest situation to reach is a full FIFO that is then drained while frames keep running. Reaching it means offering codes faster than a 12-slot frame plus its gap can consume them. The bench pushes one burst of more codes than the FIFO holds, so `codeReady` drops and stays low until a frame start frees an entry. Ticks are withheld for a stretch in the middle of a frame, and are otherwise given in an irregular pattern, to show that slot timing and the phase accumulators depend only on ticks. The bench model tracks queue contents, frame position and both phases behaviourally, and predicts the sample every cycle.

// File: rtl/twoTonePkg.sv
package twoTonePkg;

  localparam int FRAME_LEN = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SEND = 2'd1,
    SEQ_GAP  = 2'd2
  } seqState_t;

  // strobes from the sequencer to the synthesizer
  typedef struct packed {
    logic advance;
    logic clkGate;
    logic datGate;
  } toneCtrl_t;

endpackage

// File: rtl/keyQueue.sv
module keyQueue #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             notFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;

  assign headData = store[rdPtr];
  assign notEmpty = (count != '0);
  assign notFull  = (count != FULL_CNT);

  always_ff @(posedge clk) begin
    if (pushEn) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popEn)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: storage never holds more than DEPTH entries
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R2: the sequencer never pops an empty queue
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    popEn |-> (count != '0));

endmodule

// File: rtl/frameSequencer.sv
module frameSequencer
  import twoTonePkg::*;
#(
  parameter int CODE_W     = 9,
  parameter int SLOT_TICKS = 1200,
  parameter int GAP_TICKS  = 2880
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleTick,
  input  logic              codeAvail,
  input  logic [CODE_W-1:0] codeHead,
  output logic              codePop,
  output toneCtrl_t         ctrl
);
  localparam int MAX_T = (SLOT_TICKS > GAP_TICKS) ? SLOT_TICKS : GAP_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF      = CNT_W'(SLOT_TICKS / 2);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN - 1);

  seqState_t               state;
  logic [IDX_W-1:0]        slotIdx;
  logic [CNT_W-1:0]        tickCnt;
  logic [FRAME_LEN-1:0]    frameBits;
  logic [FRAME_LEN-1:0]    nextFrame;

  // stop, parity (odd), code LSB first, start
  assign nextFrame = {1'b1, ~^codeHead, codeHead, 1'b0};
  assign codePop   = (state == SEQ_IDLE) && codeAvail;

  always_comb begin
    ctrl.advance = sampleTick;
    ctrl.clkGate = (state == SEQ_SEND) && (tickCnt < HALF);
    ctrl.datGate = (state == SEQ_SEND) && frameBits[slotIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      slotIdx   <= '0;
      tickCnt   <= '0;
      frameBits <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (codeAvail) begin
            frameBits <= nextFrame;
            slotIdx   <= '0;
            tickCnt   <= '0;
            state     <= SEQ_SEND;
          end
        end
        SEQ_SEND: begin
          if (sampleTick) begin
            if (tickCnt == SLOT_LAST) begin
              tickCnt <= '0;
              if (slotIdx == IDX_LAST) state <= SEQ_GAP;
              else slotIdx <= slotIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        SEQ_GAP: begin
          if (sampleTick) begin
            if (tickCnt == GAP_LAST) begin
              tickCnt <= '0;
              state   <= SEQ_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R6: slot position stays inside the frame and the slot length
  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_SEND) |-> (slotIdx <= IDX_LAST) && (tickCnt <= SLOT_LAST));

  // R6: the last tick of slot 11 leads into the silent gap
  assert_gap_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_SEND && sampleTick && tickCnt == SLOT_LAST && slotIdx == IDX_LAST)
      |=> (state == SEQ_GAP));

  // R3: a frame in flight always has a low start and a high stop slot
  assert_frame_edges_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_SEND) |-> (frameBits[FRAME_LEN-1] && !frameBits[0]));

  // R10: a pop always starts slot 0 on the next edge
  assert_start_R10: assert property (@(posedge clk) disable iff (rst)
    codePop |=> (state == SEQ_SEND) && (slotIdx == '0) && (tickCnt == '0));

endmodule

// File: rtl/toneSynth.sv
module toneSynth
  import twoTonePkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int SAMPLE_W = 8,
  parameter int CLK_INC  = 10923,
  parameter int DAT_INC  = 6827
) (
  input  logic                clk,
  input  logic                rst,
  input  toneCtrl_t           ctrl,
  output logic [SAMPLE_W-1:0] audioSample
);
  localparam int SUM_W = SAMPLE_W + 2;
  localparam logic signed [SUM_W-1:0] MID_V = SUM_W'(2 ** (SAMPLE_W - 1));
  localparam logic signed [SUM_W-1:0] AMP_V = SUM_W'(2 ** (SAMPLE_W - 2) - 1);

  logic [PHASE_W-1:0]      clkPhase, datPhase, clkNext, datNext;
  logic signed [SUM_W-1:0] mixSum;

  assign clkNext = clkPhase + PHASE_W'(CLK_INC);
  assign datNext = datPhase + PHASE_W'(DAT_INC);

  always_comb begin
    mixSum = MID_V;
    if (ctrl.clkGate) mixSum = clkNext[PHASE_W-1] ? mixSum + AMP_V : mixSum - AMP_V;
    if (ctrl.datGate) mixSum = datNext[PHASE_W-1] ? mixSum + AMP_V : mixSum - AMP_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPhase    <= '0;
      datPhase    <= '0;
      audioSample <= MID_V[SAMPLE_W-1:0];
    end else if (ctrl.advance) begin
      clkPhase    <= clkNext;
      datPhase    <= datNext;
      audioSample <= mixSum[SAMPLE_W-1:0];
    end
  end

  // R7: the sample holds between ticks
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.advance |=> $stable(audioSample));

  // R7: accumulators move only on ticks
  assert_phase_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.advance |=> ($stable(clkPhase) && $stable(datPhase)));

endmodule

// File: rtl/twoToneKeyer.sv
module twoToneKeyer
  import twoTonePkg::*;
#(
  parameter int CODE_W     = 9,
  parameter int FIFO_DEPTH = 4,
  parameter int SAMPLE_W   = 8,
  parameter int PHASE_W    = 16,
  parameter int SLOT_TICKS = 1200,
  parameter int GAP_TICKS  = 2880,
  parameter int CLK_INC    = 10923,
  parameter int DAT_INC    = 6827
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                codeValid,
  input  logic [CODE_W-1:0]   codeIn,
  output logic                codeReady,
  input  logic                sampleTick,
  output logic [SAMPLE_W-1:0] audioSample
);
  logic              qAvail, qPop, qNotFull;
  logic [CODE_W-1:0] qHead;
  toneCtrl_t         toneCtrl;

  assign codeReady = qNotFull;

  keyQueue #(.WIDTH(CODE_W), .DEPTH(FIFO_DEPTH)) uQueue (
    .clk      (clk),
    .rst      (rst),
    .pushEn   (codeValid && qNotFull),
    .pushData (codeIn),
    .popEn    (qPop),
    .headData (qHead),
    .notEmpty (qAvail),
    .notFull  (qNotFull)
  );

  frameSequencer #(.CODE_W(CODE_W), .SLOT_TICKS(SLOT_TICKS), .GAP_TICKS(GAP_TICKS)) uSeq (
    .clk        (clk),
    .rst        (rst),
    .sampleTick (sampleTick),
    .codeAvail  (qAvail),
    .codeHead   (qHead),
    .codePop    (qPop),
    .ctrl       (toneCtrl)
  );

  toneSynth #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .CLK_INC(CLK_INC), .DAT_INC(DAT_INC)) uSynth (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (toneCtrl),
    .audioSample (audioSample)
  );

endmodule

// File: tb/tb_twoToneKeyer.sv
module tb_twoToneKeyer;
  localparam int CW = 9, DEPTH = 4, SW = 8, PW = 8;
  localparam int SLOT = 8, GAP = 10, CINC = 37, DINC = 23;
  localparam int MID = 128, AMP = 63;

  logic clk = 0, rst = 1, codeValid = 0, sampleTick = 0, codeReady;
  logic [CW-1:0] codeIn = '0;
  logic [SW-1:0] audioSample;

  twoToneKeyer #(.CODE_W(CW), .FIFO_DEPTH(DEPTH), .SAMPLE_W(SW), .PHASE_W(PW),
    .SLOT_TICKS(SLOT), .GAP_TICKS(GAP), .CLK_INC(CINC), .DAT_INC(DINC)) dut (
    .clk(clk), .rst(rst), .codeValid(codeValid), .codeIn(codeIn),
    .codeReady(codeReady), .sampleTick(sampleTick), .audioSample(audioSample));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit tickHold = 0, done = 0;

  // behavioural reference
  int q[$];
  int mState = 0;          // 0 idle, 1 send, 2 gap
  int mSlot = 0, mTick = 0, mClkPh = 0, mDatPh = 0, expSample = MID;
  bit mBits[12];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic buildFrame(int code);
    int ones = 0;
    mBits[0] = 0;                                      // R3 start
    for (int i = 0; i < 9; i++) begin
      mBits[i + 1] = code[i];
      ones += code[i];
    end
    mBits[10] = (ones % 2 == 0);                       // R3 odd parity
    mBits[11] = 1;                                     // R3 stop
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); mState = 0; mSlot = 0; mTick = 0;
      mClkPh = 0; mDatPh = 0; expSample = MID;          // R1
    end else begin
      bit canPush, cg, dg;
      canPush = q.size() < DEPTH;
      cg = (mState == 1) && (mTick < SLOT / 2);          // R5
      dg = (mState == 1) && mBits[mSlot];                // R4
      if (sampleTick) begin                              // R7 R8
        mClkPh = (mClkPh + CINC) % 256;
        mDatPh = (mDatPh + DINC) % 256;
        expSample = MID;
        if (cg) expSample += (mClkPh >= 128) ? AMP : -AMP;
        if (dg) expSample += (mDatPh >= 128) ? AMP : -AMP;
      end
      case (mState)
        0: if (q.size() > 0) begin                       // R10
             buildFrame(q.pop_front());
             mState = 1; mSlot = 0; mTick = 0;
           end
        1: if (sampleTick) begin                         // R6
             if (mTick == SLOT - 1) begin
               mTick = 0;
               if (mSlot == 11) mState = 2; else mSlot++;
             end else mTick++;
           end
        default: if (sampleTick) begin
             if (mTick == GAP - 1) begin mTick = 0; mState = 0; end
             else mTick++;
           end
      endcase
      if (codeValid && canPush) q.push_back(int'(codeIn)); // R2
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      string req;
      req = (mState == 0) ? "R10" : (mState == 2) ? "R9" : "R8";
      check(req, int'(audioSample), expSample);
      check("R2", int'(codeReady), int'(q.size() < DEPTH));
    end
  end

  // irregular tick pattern, with a hold window
  always @(negedge clk) sampleTick <= !tickHold && ((cyc % 3) != 0) && ((cyc % 7) != 2);

  task automatic pushCode(int c);
    @(negedge clk);
    codeValid = 1; codeIn = CW'(c);
    while (!codeReady) @(negedge clk);
    @(negedge clk);
    codeValid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0 || mState != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", int'(audioSample), MID);               // R1 reset sample
    check("R1", int'(codeReady), 1);                   // R1 ready
    pushCode(9'h000); drain();                         // R3 all-zero code, parity 1
    pushCode(9'h1FF); drain();                         // R3 all-ones code, parity 0
    pushCode(9'h0A5);
    repeat (40) @(negedge clk);
    tickHold = 1; repeat (50) @(negedge clk); tickHold = 0;  // R7 no ticks mid-frame
    drain();
    // R2 burst beyond the FIFO depth
    pushCode(9'h100); pushCode(9'h033); pushCode(9'h1C3);
    pushCode(9'h07E); pushCode(9'h155); pushCode(9'h0F0);
    check("R2", int'(codeReady), int'(q.size() < DEPTH));
    drain();
    check("R9", int'(audioSample), MID);               // R9 silent after last gap
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule